// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor with a single accumulator. It steps through a fixed multicycle sequence for every instruction. It fetches a 16-bit instruction word from a word-addressed memory and decodes a 4-bit opcode. It then executes one of four operations: load, store, add from memory and add immediate. All memory traffic uses two internal registers:

- The address register is the only source of the memory address.
- The buffer register is the only register that receives read data, and the only source of write data.

An instruction word travels from memory into the buffer register, and then into the instruction register before it is decoded. This leaves the buffer register free for the operand transfer.

The memory must return read data in the cycle after the read strobe. The core drives the address from its address register and raises the read or write strobe for one cycle at a time. Debug outputs show the program counter, the instruction register and the accumulator. An opcode outside the defined four stops the core until the next reset.

Top module: `accCpu`

## Requirements
- R1: While reset is held and in the first cycle after it, the program counter equals the reset parameter (default 100h), the accumulator and instruction register read zero, the halted flag is low, and both memory strobes are low.
- R2: An instruction word carries the opcode in bits 15:12 and the operand in bits 11:0. The fetch read is issued with the memory address equal to the program counter, and the fetched word appears on the instruction register output.
- R3: Opcode 0 replaces the accumulator with the memory word at the operand address.
- R4: Opcode 1 writes the accumulator to the operand address with the write strobe high for exactly one cycle, and leaves the accumulator unchanged.
- R5: Opcode 2 adds the memory word at the operand address to the accumulator, and the sum wraps modulo 2^16.
- R6: Opcode 3 adds the operand field, zero-extended to 16 bits, to the accumulator. It makes no data memory access.
- R7: The program counter advances by exactly one for every instruction fetched, whether or not the instruction is defined.
- R8: Opcodes 0 and 2 take 8 cycles each. Opcodes 1 and 3 take 6 cycles each. Read data is taken from memory in the cycle after the read strobe.
- R9: Opcodes 4 to 15 raise the halted flag 5 cycles after their fetch begins. From then on, the program counter (halt address plus one), the instruction register and the accumulator stay frozen and no strobe is raised until reset.
- R10: The program 0200h, 2201h, 1201h, 3002h, 1202h placed at 100h, with 200h=5, 201h=3 and 202h=0, leaves 201h=8, 202h=10, accumulator 10 and program counter 105h once its five instructions are done.
- R11: The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Word address, driven from the address register |
| memWdata | output | 16 | Write data, driven from the buffer register |
| memRdata | input | 16 | Read data, valid the cycle after memRd |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| dbgPc | output | 12 | Program counter |
| dbgIr | output | 16 | Instruction register |
| dbgAc | output | 16 | Accumulator |
| halted | output | 1 | High once an undefined opcode has been decoded |

## Verification
Each instruction has a fixed length: 8 cycles for a load or a memory add, and 6 for a store or an immediate add. An undefined opcode raises the halted flag on the fifth edge after its fetch begins. The bench adds up these lengths for every program it runs and counts clock edges from the release of reset to the halted flag. It then compares the two counts.

All register and memory values are sampled on falling edges. The sample is taken only at a cycle whose position follows from that sum, such as the edge that ends the fifth instruction of the reference program, or after the core has halted and is frozen.

// File: rtl/accCpuPkg.sv
package accCpuPkg;

  localparam int OpW = 4;

  typedef enum logic [OpW-1:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_ADD   = 4'd2,
    OP_ADDI  = 4'd3
  } opT;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_LOAD,
    ACC_ADD,
    ACC_ADDIMM
  } accOpT;

  typedef enum logic [3:0] {
    S_FADDR,
    S_FREAD,
    S_FCAP,
    S_IRLD,
    S_DECODE,
    S_OREAD,
    S_OCAP,
    S_EXEC,
    S_HALT
  } stateT;

  typedef struct packed {
    logic  marFromPc;
    logic  marFromIr;
    logic  mbrFromMem;
    logic  mbrFromAc;
    logic  irFromMbr;
    logic  pcInc;
    logic  memRd;
    logic  memWr;
    accOpT accOp;
  } ctlT;

endpackage

// File: rtl/accCpuPath.sv
module accCpuPath
  import accCpuPkg::*;
#(
  parameter int AddrW = 12,
  parameter logic [AddrW-1:0] PcReset = 'h100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlT                  ctl,
  input  logic [OpW+AddrW-1:0] memRdata,
  output logic [AddrW-1:0]     memAddr,
  output logic [OpW+AddrW-1:0] memWdata,
  output logic [OpW-1:0]       opcode,
  output logic [AddrW-1:0]     pc,
  output logic [OpW+AddrW-1:0] ir,
  output logic [OpW+AddrW-1:0] ac
);
  localparam int WordW = OpW + AddrW;

  logic [AddrW-1:0] mar;
  logic [WordW-1:0] mbr;
  logic [WordW-1:0] immExt;

  assign immExt = {{OpW{1'b0}}, ir[AddrW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= PcReset;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (ctl.marFromPc) begin
        mar <= pc;
      end else if (ctl.marFromIr) begin
        mar <= ir[AddrW-1:0];
      end

      if (ctl.mbrFromMem) begin
        mbr <= memRdata;
      end else if (ctl.mbrFromAc) begin
        mbr <= ac;
      end

      if (ctl.irFromMbr) ir <= mbr;
      if (ctl.pcInc)     pc <= pc + 1'b1;

      unique case (ctl.accOp)
        ACC_LOAD:   ac <= mbr;
        ACC_ADD:    ac <= ac + mbr;
        ACC_ADDIMM: ac <= ac + immExt;
        default:    ac <= ac;
      endcase
    end
  end

  assign memAddr  = mar;
  assign memWdata = mbr;
  assign opcode   = ir[WordW-1:AddrW];

endmodule

// File: rtl/accCpuCtrl.sv
module accCpuCtrl
  import accCpuPkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OpW-1:0] opcode,
  output ctlT            ctl,
  output stateT          state,
  output logic           halted
);
  stateT nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FADDR;
    else     state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    ctl.accOp = ACC_HOLD;
    nextState = state;
    unique case (state)
      S_FADDR: begin
        ctl.marFromPc = 1'b1;
        nextState     = S_FREAD;
      end
      S_FREAD: begin
        ctl.memRd = 1'b1;
        nextState = S_FCAP;
      end
      S_FCAP: begin
        ctl.mbrFromMem = 1'b1;
        nextState      = S_IRLD;
      end
      S_IRLD: begin
        ctl.irFromMbr = 1'b1;
        ctl.pcInc     = 1'b1;
        nextState     = S_DECODE;
      end
      S_DECODE: begin
        unique case (opcode)
          OP_LOAD, OP_ADD: begin
            ctl.marFromIr = 1'b1;
            nextState     = S_OREAD;
          end
          OP_STORE: begin
            ctl.marFromIr = 1'b1;
            ctl.mbrFromAc = 1'b1;
            nextState     = S_EXEC;
          end
          OP_ADDI: nextState = S_EXEC;
          default: nextState = S_HALT;
        endcase
      end
      S_OREAD: begin
        ctl.memRd = 1'b1;
        nextState = S_OCAP;
      end
      S_OCAP: begin
        ctl.mbrFromMem = 1'b1;
        nextState      = S_EXEC;
      end
      S_EXEC: begin
        unique case (opcode)
          OP_LOAD:  ctl.accOp = ACC_LOAD;
          OP_ADD:   ctl.accOp = ACC_ADD;
          OP_ADDI:  ctl.accOp = ACC_ADDIMM;
          OP_STORE: ctl.memWr = 1'b1;
          default:  ctl.accOp = ACC_HOLD;
        endcase
        nextState = S_FADDR;
      end
      S_HALT:  nextState = S_HALT;
      default: nextState = S_FADDR;
    endcase
  end

  assign halted = (state == S_HALT);

  // R4: a store strobe lasts a single cycle
  a_r4_write_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ctl.memWr |=> !ctl.memWr);

  // R8: each read strobe is followed by a capture into the buffer register
  a_r8_capture_after_read: assert property (@(posedge clk) disable iff (rst)
    ctl.memRd |=> ctl.mbrFromMem);

endmodule

// File: rtl/accCpu.sv
module accCpu
  import accCpuPkg::*;
#(
  parameter int AddrW = 12,
  parameter logic [AddrW-1:0] PcReset = 'h100
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [AddrW-1:0]     memAddr,
  output logic [OpW+AddrW-1:0] memWdata,
  input  logic [OpW+AddrW-1:0] memRdata,
  output logic                 memRd,
  output logic                 memWr,
  output logic [AddrW-1:0]     dbgPc,
  output logic [OpW+AddrW-1:0] dbgIr,
  output logic [OpW+AddrW-1:0] dbgAc,
  output logic                 halted
);
  ctlT            ctl;
  stateT          state;
  logic [OpW-1:0] opcode;

  accCpuCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctl    (ctl),
    .state  (state),
    .halted (halted)
  );

  accCpuPath #(.AddrW(AddrW), .PcReset(PcReset)) u_path (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .pc       (dbgPc),
    .ir       (dbgIr),
    .ac       (dbgAc)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;

  // R11: strobes are mutually exclusive
  a_r11_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

  // R2: the fetch read addresses the program counter
  a_r2_fetch_addr_is_pc: assert property (@(posedge clk) disable iff (rst)
    (state == S_FREAD) |-> (memAddr == dbgPc));

  // R4: store data equals the accumulator
  a_r4_store_data_is_ac: assert property (@(posedge clk) disable iff (rst)
    memWr |-> (memWdata == dbgAc));

  // R9: halted is sticky and freezes the visible registers
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(dbgPc) && $stable(dbgIr) && $stable(dbgAc)));

  // R9: no strobes while halted
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !(memRd || memWr));

endmodule

// File: tb/sim_accCpu.sv
module sim_accCpu;
  localparam int ClkPeriod = 10;
  localparam int AddrW = 12;
  localparam int WordW = 16;
  localparam int ProgBase = 'h100;
  localparam int DataBase = 'h200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AddrW-1:0] memAddr;
  logic [WordW-1:0] memWdata;
  logic [WordW-1:0] memRdata;
  logic memRd, memWr;
  logic [AddrW-1:0] dbgPc;
  logic [WordW-1:0] dbgIr, dbgAc;
  logic halted;

  always #(ClkPeriod/2) clk = ~clk;

  accCpu u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRd(memRd), .memWr(memWr), .dbgPc(dbgPc),
    .dbgIr(dbgIr), .dbgAc(dbgAc), .halted(halted)
  );

  logic [WordW-1:0] mem [0:(1<<AddrW)-1];
  logic [WordW-1:0] rdReg;
  int wrCnt = 0;
  int conflictCnt = 0;
  int haltStrobeCnt = 0;

  assign memRdata = rdReg;

  always @(posedge clk) begin
    if (memWr) mem[memAddr] <= memWdata;
    if (memRd) rdReg <= mem[memAddr];
    if (!rst) begin
      if (memWr) wrCnt++;
      if (memRd && memWr) conflictCnt++;
      if (halted && (memRd || memWr)) haltStrobeCnt++;
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(ClkPeriod * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  function automatic int instCycles(input logic [3:0] op);
    return (op == 4'd0 || op == 4'd2) ? 8 : 6;
  endfunction

  task automatic holdReset();
    rst = 1'b1;
    wrCnt = 0;
    haltStrobeCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic runToHalt(output int cyc);
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  logic [WordW-1:0] prog [0:15];
  logic [WordW-1:0] expData [0:15];

  initial begin
    int cyc;
    void'($urandom(32'h1a2b3c4d));
    for (int a = 0; a < (1 << AddrW); a++) mem[a] = '0;
    rdReg = '0;

    // ---------------- reference program, R10
    mem[ProgBase+0] = 16'h0200;
    mem[ProgBase+1] = 16'h2201;
    mem[ProgBase+2] = 16'h1201;
    mem[ProgBase+3] = 16'h3002;
    mem[ProgBase+4] = 16'h1202;
    mem[ProgBase+5] = 16'hF000;
    mem['h200] = 16'd5;
    mem['h201] = 16'd3;
    mem['h202] = 16'd0;
    holdReset();

    // R1: values while reset is held
    chk(dbgPc == 12'h100, "R1", "pc in reset", dbgPc, 12'h100);
    chk(dbgAc == 0, "R1", "ac in reset", dbgAc, 0);
    chk(dbgIr == 0, "R1", "ir in reset", dbgIr, 0);
    chk(!halted && !memRd && !memWr, "R1", "flags in reset",
        {halted, memRd, memWr}, 0);
    rst = 1'b0;

    // R8: the first read strobe comes one cycle after release, at the pc
    runCycles(1);
    chk(memRd && memAddr == 12'h100, "R2", "fetch read at pc",
        {memRd, memAddr}, {1'b1, 12'h100});
    runCycles(3);
    chk(dbgIr == 16'h0200, "R2", "fetched word in ir", dbgIr, 16'h0200);
    chk(dbgPc == 12'h101, "R7", "pc stepped after fetch", dbgPc, 12'h101);
    // five instructions: 8+8+6+6+6 = 34 cycles in total
    runCycles(30);
    chk(dbgPc == 12'h105, "R10", "pc after program", dbgPc, 12'h105);
    chk(dbgAc == 16'd10, "R10", "ac after program", dbgAc, 16'd10);
    chk(mem['h201] == 16'd8, "R10", "mem 201h", mem['h201], 16'd8);
    chk(mem['h202] == 16'd10, "R10", "mem 202h", mem['h202], 16'd10);
    chk(wrCnt == 2, "R4", "store count", wrCnt, 2);
    runCycles(4);
    chk(!halted, "R9", "not yet halted", halted, 0);
    runCycles(1);
    chk(halted, "R9", "halted 5 cycles after fetch start", halted, 1);
    chk(dbgPc == 12'h106, "R9", "pc after halt", dbgPc, 12'h106);
    runCycles(20);
    chk(halted && dbgPc == 12'h106 && dbgIr == 16'hF000 && dbgAc == 16'd10,
        "R9", "frozen state", {dbgPc, dbgIr}, {12'h106, 16'hF000});
    chk(haltStrobeCnt == 0, "R9", "strobes while halted", haltStrobeCnt, 0);

    // ---------------- wrap and zero extension, R5 R6
    mem[ProgBase+0] = 16'h0210;   // load FFFF
    mem[ProgBase+1] = 16'h2211;   // add 0001 -> 0000
    mem[ProgBase+2] = 16'h3FFF;   // add imm 0FFF
    mem[ProgBase+3] = 16'h4123;   // undefined
    mem['h210] = 16'hFFFF;
    mem['h211] = 16'h0001;
    holdReset();
    rst = 1'b0;
    runCycles(8);
    chk(dbgAc == 16'hFFFF, "R3", "load value", dbgAc, 16'hFFFF);
    runCycles(8);
    chk(dbgAc == 16'h0000, "R5", "add wraps to zero", dbgAc, 0);
    runCycles(6);
    chk(dbgAc == 16'h0FFF, "R6", "immediate zero-extended", dbgAc, 16'h0FFF);
    runToHalt(cyc);
    chk(cyc == 5, "R9", "opcode 4 halts", cyc, 5);
    chk(wrCnt == 0, "R6", "no writes without stores", wrCnt, 0);

    // ---------------- random programs
    for (int it = 0; it < 25; it++) begin
      int n;
      int expCyc;
      int expWr;
      logic [WordW-1:0] acm;
      logic [WordW-1:0] haltWord;
      n = 4 + int'($urandom % 12);
      for (int d = 0; d < 16; d++) begin
        expData[d] = WordW'($urandom);
        mem[DataBase+d] = expData[d];
      end
      acm = '0;
      expCyc = 0;
      expWr = 0;
      for (int k = 0; k < n; k++) begin
        logic [3:0] op;
        logic [3:0] off;
        op = 4'($urandom % 4);
        off = 4'($urandom);
        if (op == 4'd3) prog[k] = {op, 12'($urandom)};
        else            prog[k] = {op, 12'(DataBase) + {8'h0, off}};
        mem[ProgBase+k] = prog[k];
        unique case (op)
          4'd0: acm = expData[off];
          4'd1: begin expData[off] = acm; expWr++; end
          4'd2: acm = acm + expData[off];
          default: acm = acm + {4'h0, prog[k][11:0]};
        endcase
        expCyc += instCycles(op);
      end
      haltWord = {4'(4 + ($urandom % 12)), 12'($urandom)};
      mem[ProgBase+n] = haltWord;
      holdReset();
      rst = 1'b0;
      runToHalt(cyc);
      chk(cyc == expCyc + 5, "R8", "cycles to halt", cyc, expCyc + 5);
      chk(dbgAc == acm, "R3", "random final ac", dbgAc, acm);
      chk(dbgPc == 12'(ProgBase + n + 1), "R7", "random final pc",
          dbgPc, ProgBase + n + 1);
      chk(dbgIr == haltWord, "R9", "halt word held", dbgIr, haltWord);
      chk(wrCnt == expWr, "R4", "random store count", wrCnt, expWr);
      for (int d = 0; d < 16; d++)
        chk(mem[DataBase+d] == expData[d], "R4", "random data word",
            mem[DataBase+d], expData[d]);
    end

    chk(conflictCnt == 0, "R11", "read and write together", conflictCnt, 0);
    finishRun();
  end

endmodule